// File: doc/BRIEF.md
# Complementary PWM Channel with Dead-Time Insertion

This block generates one pulse-width-modulated channel as a pair of complementary outputs, a high side and a low side, for driving a half bridge. A counter advances on a qualified clock enable and runs either as an up-counter that wraps (edge-aligned) or as an up/down counter (symmetric). The counter is compared against the duty value to form a raw waveform. Separate rising-edge delays for each side then keep the two outputs from being active at the same time.

Software-facing values (period, duty, both dead-times and the polarity bit) are written through a single strobe into shadow storage. They reach the working copy only at a waveform boundary, so a write never tears the pulse in progress. In symmetric mode the channel can also take new values at the turning point. Per-side override inputs can force either pin to a fixed level. Single-cycle event pulses mark the end of each period and, in symmetric mode, the turning point.

Top module: `pwm_dt_channel`

## Requirements
- R1: While `ch_en` is low, the counter is held at zero, no events are raised, and from the second clock after `ch_en` falls both pins sit at their inactive level, which equals the polarity bit, unless an override applies.
- R2: In edge-aligned mode (`center_mode`=0), the counter steps 0,1,…,PRD and then returns to 0, and `evt_period` pulses once every PRD+1 ticks.
- R3: In symmetric mode (`center_mode`=1, PRD ≥ 2), the counter rises from 0 to PRD and falls back to 1, giving a period of 2·PRD ticks. `evt_period` pulses on the return to 0 and `evt_half` pulses on leaving PRD. `evt_half` never pulses in edge-aligned mode.
- R4: The raw waveform is active while the counter is below DUTY. DUTY = 0 gives a permanently inactive raw waveform, and a nonzero DUTY ≥ PRD gives a permanently active one.
- R5: The high side follows the raw waveform and the low side follows its inverse, each one clock later, with each rising edge held back a further DTH (high) or DTL (low) ticks. Before polarity, the two sides are never active together.
- R6: When a side's delay is at least as long as its active interval, that side stays inactive for the whole interval.
- R7: Polarity bit 1 inverts both pins. Polarity bit 0 makes an active side drive 1.
- R8: A pulse on `wr_stb` copies all five `wr_*` fields into shadow storage. While enabled, the working values are taken from the shadow only at the end of a period; while disabled they track the shadow.
- R9: With `upd_half`=1 in symmetric mode, the working values are also taken from the shadow at the turning point, so a duty write takes effect in the falling half of the same period.
- R10: When `ovr_en_h` or `ovr_en_l` is high, that pin drives `ovr_val_h` or `ovr_val_l` directly, ignoring the waveform and polarity. The other pin is unaffected.
- R11: The counter, the dead-time delays and the events advance only on clocks where `tick_en` is high. When ticks arrive every second clock, the period in clocks doubles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Selected clock enable that advances the channel |
| ch_en | input | 1 | Channel enable |
| center_mode | input | 1 | 1 = symmetric up/down counting, 0 = edge-aligned |
| upd_half | input | 1 | Also load working values at the turning point (symmetric mode) |
| wr_stb | input | 1 | Captures the wr_* fields into shadow storage |
| wr_prd | input | CNT_W | Period value |
| wr_duty | input | CNT_W | Duty value |
| wr_dth | input | DT_W | High-side rising delay in ticks |
| wr_dtl | input | DT_W | Low-side rising delay in ticks |
| wr_pol | input | 1 | Polarity bit, 1 inverts both pins |
| ovr_en_h | input | 1 | Force the high-side pin |
| ovr_val_h | input | 1 | Forced high-side level |
| ovr_en_l | input | 1 | Force the low-side pin |
| ovr_val_l | input | 1 | Forced low-side level |
| pwm_h | output | 1 | High-side pin |
| pwm_l | output | 1 | Low-side pin |
| evt_period | output | 1 | One-clock pulse at each period end |
| evt_half | output | 1 | One-clock pulse at the symmetric-mode turning point |

## Verification
The bench builds the block with its default widths, a 16-bit counter and 12-bit dead-times, and runs it with small periods (5, 9 and 19) so that every period, every turning point and every dead-time edge fits inside short windows. Because the windows span whole periods, the high-time and low-time counts are exact whatever the phase. This makes dead-time shortening, delays longer than the pulse, and the 0 and ≥ PRD duty extremes all directly comparable. Small values also let a single write placed on a period boundary show the one-period delay of the double buffering, and show how choosing the turning-point update changes the very next pulse.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

  localparam int SIDE_HI = 0;
  localparam int SIDE_LO = 1;
  localparam int NSIDE   = 2;
endpackage

// File: rtl/pwm_dt_shadow.sv
module pwm_dt_shadow #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [CNT_W-1:0] wr_prd,
  input  logic [CNT_W-1:0] wr_duty,
  input  logic [DT_W-1:0]  wr_dth,
  input  logic [DT_W-1:0]  wr_dtl,
  input  logic             wr_pol,
  input  logic             load,
  output logic [CNT_W-1:0] prd_o,
  output logic [CNT_W-1:0] duty_o,
  output logic [DT_W-1:0]  dth_o,
  output logic [DT_W-1:0]  dtl_o,
  output logic             pol_o
);
  logic [CNT_W-1:0] sh_prd_q, sh_duty_q, sh_prd_d, sh_duty_d;
  logic [DT_W-1:0]  sh_dth_q, sh_dtl_q, sh_dth_d, sh_dtl_d;
  logic             sh_pol_q, sh_pol_d;

  logic [CNT_W-1:0] ac_prd_q, ac_duty_q, ac_prd_d, ac_duty_d;
  logic [DT_W-1:0]  ac_dth_q, ac_dtl_q, ac_dth_d, ac_dtl_d;
  logic             ac_pol_q, ac_pol_d;

  always_comb begin
    sh_prd_d  = sh_prd_q;
    sh_duty_d = sh_duty_q;
    sh_dth_d  = sh_dth_q;
    sh_dtl_d  = sh_dtl_q;
    sh_pol_d  = sh_pol_q;
    if (wr_stb) begin
      sh_prd_d  = wr_prd;
      sh_duty_d = wr_duty;
      sh_dth_d  = wr_dth;
      sh_dtl_d  = wr_dtl;
      sh_pol_d  = wr_pol;
    end
  end

  always_comb begin
    ac_prd_d  = ac_prd_q;
    ac_duty_d = ac_duty_q;
    ac_dth_d  = ac_dth_q;
    ac_dtl_d  = ac_dtl_q;
    ac_pol_d  = ac_pol_q;
    if (load) begin
      ac_prd_d  = sh_prd_q;
      ac_duty_d = sh_duty_q;
      ac_dth_d  = sh_dth_q;
      ac_dtl_d  = sh_dtl_q;
      ac_pol_d  = sh_pol_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_prd_q  <= '0;
      sh_duty_q <= '0;
      sh_dth_q  <= '0;
      sh_dtl_q  <= '0;
      sh_pol_q  <= 1'b0;
      ac_prd_q  <= '0;
      ac_duty_q <= '0;
      ac_dth_q  <= '0;
      ac_dtl_q  <= '0;
      ac_pol_q  <= 1'b0;
    end else begin
      sh_prd_q  <= sh_prd_d;
      sh_duty_q <= sh_duty_d;
      sh_dth_q  <= sh_dth_d;
      sh_dtl_q  <= sh_dtl_d;
      sh_pol_q  <= sh_pol_d;
      ac_prd_q  <= ac_prd_d;
      ac_duty_q <= ac_duty_d;
      ac_dth_q  <= ac_dth_d;
      ac_dtl_q  <= ac_dtl_d;
      ac_pol_q  <= ac_pol_d;
    end
  end

  assign prd_o  = ac_prd_q;
  assign duty_o = ac_duty_q;
  assign dth_o  = ac_dth_q;
  assign dtl_o  = ac_dtl_q;
  assign pol_o  = ac_pol_q;
endmodule

// File: rtl/pwm_dt_counter.sv
module pwm_dt_counter
  import pwm_dt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             center,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt_o,
  output logic             prd_bnd_o,
  output logic             half_bnd_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cnt_dir_e         dir_q, dir_d;
  logic             prd_bnd, half_bnd;

  always_comb begin
    cnt_d    = cnt_q;
    dir_d    = dir_q;
    prd_bnd  = 1'b0;
    half_bnd = 1'b0;
    if (!en) begin
      cnt_d = '0;
      dir_d = DIR_UP;
    end else if (tick) begin
      if (!center) begin
        dir_d = DIR_UP;
        if (cnt_q >= prd) begin
          cnt_d   = '0;
          prd_bnd = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (dir_q == DIR_UP) begin
        if (cnt_q >= prd) begin
          if (cnt_q == '0) begin
            cnt_d   = '0;
            prd_bnd = 1'b1;
          end else begin
            cnt_d    = cnt_q - ONE;
            dir_d    = DIR_DOWN;
            half_bnd = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q <= ONE) begin
          cnt_d   = '0;
          dir_d   = DIR_UP;
          prd_bnd = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign prd_bnd_o  = prd_bnd;
  assign half_bnd_o = half_bnd;
endmodule

// File: rtl/pwm_dt_edge_delay.sv
module pwm_dt_edge_delay #(
  parameter int DT_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tick,
  input  logic            din,
  input  logic [DT_W-1:0] dly,
  output logic            dout
);
  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  logic            q_q, q_d;
  logic [DT_W-1:0] wait_q, wait_d;

  always_comb begin
    q_d    = q_q;
    wait_d = wait_q;
    if (!en || !din) begin
      q_d    = 1'b0;
      wait_d = '0;
    end else if (!q_q) begin
      if (wait_q >= dly) begin
        q_d = 1'b1;
      end else if (tick) begin
        wait_d = wait_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= 1'b0;
      wait_q <= '0;
    end else begin
      q_q    <= q_d;
      wait_q <= wait_d;
    end
  end

  assign dout = q_q;
endmodule

// File: rtl/pwm_dt_channel.sv
module pwm_dt_channel
  import pwm_dt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ch_en,
  input  logic             center_mode,
  input  logic             upd_half,
  input  logic             wr_stb,
  input  logic [CNT_W-1:0] wr_prd,
  input  logic [CNT_W-1:0] wr_duty,
  input  logic [DT_W-1:0]  wr_dth,
  input  logic [DT_W-1:0]  wr_dtl,
  input  logic             wr_pol,
  input  logic             ovr_en_h,
  input  logic             ovr_val_h,
  input  logic             ovr_en_l,
  input  logic             ovr_val_l,
  output logic             pwm_h,
  output logic             pwm_l,
  output logic             evt_period,
  output logic             evt_half
);
  logic [CNT_W-1:0] prd_act, duty_act, cnt;
  logic [DT_W-1:0]  dth_act, dtl_act;
  logic             pol_act;
  logic             prd_bnd, half_bnd, load;
  logic             raw;
  logic [NSIDE-1:0] dt_in, side_q;
  logic [DT_W-1:0]  side_dly [NSIDE];
  logic             evt_period_q, evt_period_d, evt_half_q, evt_half_d;

  assign load = !ch_en | prd_bnd | (upd_half & center_mode & half_bnd);

  pwm_dt_shadow #(.CNT_W(CNT_W), .DT_W(DT_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_prd  (wr_prd),
    .wr_duty (wr_duty),
    .wr_dth  (wr_dth),
    .wr_dtl  (wr_dtl),
    .wr_pol  (wr_pol),
    .load    (load),
    .prd_o   (prd_act),
    .duty_o  (duty_act),
    .dth_o   (dth_act),
    .dtl_o   (dtl_act),
    .pol_o   (pol_act)
  );

  pwm_dt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ch_en),
    .tick       (tick_en),
    .center     (center_mode),
    .prd        (prd_act),
    .cnt_o      (cnt),
    .prd_bnd_o  (prd_bnd),
    .half_bnd_o (half_bnd)
  );

  assign raw = (duty_act != '0) && ((cnt < duty_act) || (duty_act >= prd_act));

  assign dt_in[SIDE_HI]    = raw;
  assign dt_in[SIDE_LO]    = ~raw;
  assign side_dly[SIDE_HI] = dth_act;
  assign side_dly[SIDE_LO] = dtl_act;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    pwm_dt_edge_delay #(.DT_W(DT_W)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ch_en),
      .tick  (tick_en),
      .din   (dt_in[g]),
      .dly   (side_dly[g]),
      .dout  (side_q[g])
    );
  end

  always_comb begin
    evt_period_d = prd_bnd;
    evt_half_d   = half_bnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_period_q <= 1'b0;
      evt_half_q   <= 1'b0;
    end else begin
      evt_period_q <= evt_period_d;
      evt_half_q   <= evt_half_d;
    end
  end

  assign evt_period = evt_period_q;
  assign evt_half   = evt_half_q;
  assign pwm_h = ovr_en_h ? ovr_val_h : (side_q[SIDE_HI] ^ pol_act);
  assign pwm_l = ovr_en_l ? ovr_val_l : (side_q[SIDE_LO] ^ pol_act);
endmodule

// File: rtl/pwm_dt_channel_chk.sv
module pwm_dt_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ch_en,
  input logic             tick_en,
  input logic             center_mode,
  input logic             evt_period,
  input logic             evt_half,
  input logic [1:0]       side_q,
  input logic [1:0]       dt_in,
  input logic [CNT_W-1:0] duty_act
);
  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(side_q[0] && side_q[1]));

  // R1
  idle_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> (!evt_period && !evt_half));

  // R1
  idle_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> (side_q == 2'b00));

  // R3
  left_no_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !center_mode |=> !evt_half);

  // R6
  hi_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(side_q[0]) |-> $past(dt_in[0]));

  // R6
  lo_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(side_q[1]) |-> $past(dt_in[1]));

  // R11
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !tick_en) |=> $stable(duty_act));

  // R11
  evt_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> !evt_period);
endmodule

bind pwm_dt_channel pwm_dt_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ch_en       (ch_en),
  .tick_en     (tick_en),
  .center_mode (center_mode),
  .evt_period  (evt_period),
  .evt_half    (evt_half),
  .side_q      (side_q),
  .dt_in       (dt_in),
  .duty_act    (duty_act)
);

// File: tb/tb_pwm_dt_channel.sv
module tb_pwm_dt_channel;
  localparam int CNT_W = 16;
  localparam int DT_W  = 12;

  logic clk, rst_n, tick_en, ch_en, center_mode, upd_half, wr_stb;
  logic [CNT_W-1:0] wr_prd, wr_duty;
  logic [DT_W-1:0]  wr_dth, wr_dtl;
  logic wr_pol, ovr_en_h, ovr_val_h, ovr_en_l, ovr_val_l;
  logic pwm_h, pwm_l, evt_period, evt_half;

  int n_tests, n_fail;
  logic done;

  pwm_dt_channel #(.CNT_W(CNT_W), .DT_W(DT_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ch_en(ch_en),
    .center_mode(center_mode), .upd_half(upd_half), .wr_stb(wr_stb),
    .wr_prd(wr_prd), .wr_duty(wr_duty), .wr_dth(wr_dth), .wr_dtl(wr_dtl),
    .wr_pol(wr_pol), .ovr_en_h(ovr_en_h), .ovr_val_h(ovr_val_h),
    .ovr_en_l(ovr_en_l), .ovr_val_l(ovr_val_l), .pwm_h(pwm_h),
    .pwm_l(pwm_l), .evt_period(evt_period), .evt_half(evt_half)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic configure(input int prd, input int duty, input int dth, input int dtl,
                           input logic pol, input logic ctr, input logic uh);
    @(negedge clk);
    ch_en = 1'b0;
    wr_prd = CNT_W'(prd); wr_duty = CNT_W'(duty);
    wr_dth = DT_W'(dth);  wr_dtl = DT_W'(dtl);
    wr_pol = pol; center_mode = ctr; upd_half = uh;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_settle();
    ch_en = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic count_window(input int n, output int hc, output int lc,
                              output int ov, output int hv);
    hc = 0; lc = 0; ov = 0; hv = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_h) hc++;
      if (pwm_l) lc++;
      if (pwm_h && pwm_l) ov++;
      if (evt_half) hv++;
    end
  endtask

  task automatic wait_evt();
    int t;
    t = 0;
    while (!evt_period && t < 500) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic next_gap(output int gap);
    gap = 1;
    @(negedge clk);
    wr_stb = 1'b0;
    while (!evt_period && gap < 500) begin
      @(negedge clk);
      gap++;
    end
  endtask

  task automatic t_reset();
    check("R1 reset pwm_h", int'(pwm_h), 0);
    check("R1 reset pwm_l", int'(pwm_l), 0);
    check("R1 reset events", int'(evt_period | evt_half), 0);
  endtask

  task automatic t_left();
    int gap, hc, lc, ov, hv;
    configure(9, 4, 0, 0, 1'b0, 1'b0, 1'b0);
    run_settle();
    wait_evt();
    next_gap(gap);
    check("R2 edge-aligned period", gap, 10);
    count_window(100, hc, lc, ov, hv);
    check("R4 high-side time", hc, 40);
    check("R4 low-side time", lc, 60);
    check("R5 overlap", ov, 0);
    check("R3 no half event in edge-aligned", hv, 0);
  endtask

  task automatic t_deadtime();
    int hc, lc, ov, hv;
    configure(9, 4, 2, 1, 1'b0, 1'b0, 1'b0);
    run_settle();
    count_window(100, hc, lc, ov, hv);
    check("R5 high side shortened by DTH", hc, 20);
    check("R5 low side shortened by DTL", lc, 50);
    check("R5 overlap with dead-time", ov, 0);
    configure(9, 4, 5, 1, 1'b0, 1'b0, 1'b0);
    run_settle();
    count_window(100, hc, lc, ov, hv);
    check("R6 delay beyond pulse keeps side low", hc, 0);
    check("R6 other side unaffected", lc, 50);
  endtask

  task automatic t_duty_ext();
    int hc, lc, ov, hv;
    configure(9, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    run_settle();
    count_window(100, hc, lc, ov, hv);
    check("R4 duty zero high", hc, 0);
    check("R4 duty zero low", lc, 100);
    configure(9, 12, 0, 0, 1'b0, 1'b0, 1'b0);
    run_settle();
    count_window(100, hc, lc, ov, hv);
    check("R4 duty above period high", hc, 100);
    check("R4 duty above period low", lc, 0);
  endtask

  task automatic t_center();
    int gap, hc, lc, ov, hv;
    configure(5, 2, 0, 0, 1'b0, 1'b1, 1'b0);
    run_settle();
    wait_evt();
    next_gap(gap);
    check("R3 symmetric period", gap, 10);
    count_window(100, hc, lc, ov, hv);
    check("R3 half events per 10 periods", hv, 10);
    check("R4 symmetric high time", hc, 30);
    check("R4 symmetric low time", lc, 70);
  endtask

  task automatic t_polarity();
    int hc, lc, ov, hv;
    configure(9, 4, 0, 0, 1'b1, 1'b0, 1'b0);
    check("R1 idle high pin equals polarity", int'(pwm_h), 1);
    check("R1 idle low pin equals polarity", int'(pwm_l), 1);
    run_settle();
    count_window(100, hc, lc, ov, hv);
    check("R7 inverted high pin", hc, 60);
    check("R7 inverted low pin", lc, 40);
  endtask

  task automatic t_override();
    int hc, lc, ov, hv;
    configure(9, 4, 0, 0, 1'b0, 1'b0, 1'b0);
    run_settle();
    ovr_en_h = 1'b1; ovr_val_h = 1'b0;
    count_window(100, hc, lc, ov, hv);
    check("R10 forced high pin", hc, 0);
    check("R10 low pin unaffected", lc, 60);
    ovr_en_h = 1'b0;
    ovr_en_l = 1'b1; ovr_val_l = 1'b1;
    count_window(100, hc, lc, ov, hv);
    check("R10 high pin unaffected", hc, 40);
    check("R10 forced low pin", lc, 100);
    ovr_en_l = 1'b0; ovr_val_l = 1'b0;
  endtask

  task automatic t_buffer();
    int gap;
    configure(9, 4, 0, 0, 1'b0, 1'b0, 1'b0);
    run_settle();
    wait_evt();
    wr_prd = CNT_W'(19);
    wr_stb = 1'b1;
    next_gap(gap);
    check("R8 current period kept", gap, 10);
    next_gap(gap);
    check("R8 new period applied", gap, 20);
  endtask

  task automatic half_case(input logic uh, input int exp, input string req);
    int hc;
    configure(5, 2, 0, 0, 1'b0, 1'b1, uh);
    run_settle();
    wait_evt();
    wr_duty = CNT_W'(4);
    wr_stb = 1'b1;
    hc = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      wr_stb = 1'b0;
      if (pwm_h) hc++;
    end
    check(req, hc, exp);
  endtask

  task automatic t_half_update();
    half_case(1'b1, 5, "R9 duty taken at turning point");
    half_case(1'b0, 3, "R8 duty held to period end");
  endtask

  task automatic t_disable();
    int hc, lc, ov, hv;
    configure(9, 4, 0, 0, 1'b0, 1'b0, 1'b0);
    run_settle();
    ch_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 disabled high pin", int'(pwm_h), 0);
    check("R1 disabled low pin", int'(pwm_l), 0);
    count_window(30, hc, lc, ov, hv);
    check("R1 disabled pins stay inactive", hc + lc, 0);
    check("R1 disabled no half events", hv, 0);
  endtask

  task automatic t_tick();
    int first, second, idx;
    configure(9, 4, 0, 0, 1'b0, 1'b0, 1'b0);
    ch_en = 1'b1;
    first = -1; second = -1; idx = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (evt_period) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
      tick_en = ~tick_en;
    end
    tick_en = 1'b1;
    idx = second - first;
    check("R11 period with half-rate ticks", idx, 20);
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; tick_en = 1'b1; ch_en = 1'b0; center_mode = 1'b0;
    upd_half = 1'b0; wr_stb = 1'b0; wr_prd = '0; wr_duty = '0;
    wr_dth = '0; wr_dtl = '0; wr_pol = 1'b0;
    ovr_en_h = 1'b0; ovr_val_h = 1'b0; ovr_en_l = 1'b0; ovr_val_l = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_left();
    t_deadtime();
    t_duty_ext();
    t_center();
    t_polarity();
    t_override();
    t_buffer();
    t_half_update();
    t_disable();
    t_tick();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule